// File: doc/BRIEF.md
# Three-Segment Gamma Curve Evaluator

This block maps one colour-channel sample per clock through a gamma curve stored as three nested lookup tables. The input is an unsigned fixed-point value with 18 fractional bits, so 2^18 stands for 1.0. The block keeps more precision in the dark end of the curve by choosing one of three tables from the input's magnitude. The superfine table has a step of 2^-18. The fine table has a step of 2^-15. The coarse table has a step of 2^-8.

Inside the chosen table, the block reads the two entries that bracket the input and interpolates linearly between them, then registers a 16-bit result. Inputs of 1.0 or more return a separate clamp-maximum value. That value also serves as the upper bracket of the last coarse interval.

The tables live outside the block behind plain synchronous read ports. Read data must return one clock after the address. The block issues a new lookup every cycle, and each result appears a fixed three cycles after its input.

Top module: `gamma_seg_eval`

## Requirements
- R1: `valid_o` equals `valid_i` from three clock edges earlier. A new sample is accepted on every cycle, with no gaps needed between samples.
- R2: An input x with x < 8 produces exactly superfine entry x.
- R3: An input with 8 <= x < 2048 uses fine index k = x>>3 and fraction f = x&7 (3 bits). The two brackets are fine entries k and k+1.
- R4: An input with 2048 <= x < 2^18 uses coarse index k = x>>10 and fraction f = x&1023 (10 bits). The two brackets are coarse entries k and k+1.
- R5: For a lower bracket a, an upper bracket b and a fraction f of F bits, the result is a + floor(((b-a)·f·2^(10-F) + 512) / 1024). Halfway cases therefore round toward the upper value. The difference b-a may be negative.
- R6: For coarse index 255, the upper bracket is `clamp_max_i`, not a table entry.
- R7: Any input with x >= 2^18 (any of bits 19:18 set) produces `clamp_max_i`.
- R8: While `rst_ni` is low, `valid_o` and `data_o` are 0.
- R9: In a cycle where `valid_o` is low, `data_o` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample is valid |
| data_i | input | 20 | Input sample, unsigned, 18 fractional bits |
| clamp_max_i | input | 16 | Value returned at 1.0 and above |
| sf_addr_o | output | 4 | Superfine table read address |
| sf_data_i | input | 16 | Superfine read data, one cycle after the address |
| fine_addr_a_o | output | 9 | Fine table address, lower bracket |
| fine_addr_b_o | output | 9 | Fine table address, upper bracket |
| fine_data_a_i | input | 16 | Fine read data, lower bracket |
| fine_data_b_i | input | 16 | Fine read data, upper bracket |
| crs_addr_a_o | output | 8 | Coarse table address, lower bracket |
| crs_addr_b_o | output | 8 | Coarse table address, upper bracket |
| crs_data_a_i | input | 16 | Coarse read data, lower bracket |
| crs_data_b_i | input | 16 | Coarse read data, upper bracket |
| valid_o | output | 1 | Output sample is valid |
| data_o | output | 16 | Output sample |

## Verification
Each table is filled with distinct, non-monotonic contents, so any error inside the block gives a wrong `data_o` exactly three cycles after the input that caused it:
- A wrong segment choice, index or fraction selects different brackets.
- A lost or extra pipeline bit shows on `valid_o` in that same cycle.
- An error in the clamp path shows at the top of the coarse range and above 1.0.
- Rounding errors show at fractions of exactly one half, in both rising and falling intervals.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  typedef enum logic [1:0] {
    SEG_SF   = 2'd0,
    SEG_FINE = 2'd1,
    SEG_CRS  = 2'd2,
    SEG_SAT  = 2'd3
  } gseg_e;
endpackage

// File: rtl/gamma_seg_select.sv
module gamma_seg_select
  import gamma_pkg::*;
#(
  parameter int IN_W      = 20,
  parameter int FRAC_W    = 18,
  parameter int SF_BITS   = 3,
  parameter int FINE_BITS = 8,
  parameter int CRS_BITS  = 8,
  localparam int FINE_TOP = SF_BITS + FINE_BITS,
  localparam int IP_W     = FRAC_W - CRS_BITS,
  localparam int IDX_W    = FINE_BITS + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  data_i,
  output logic             s1_valid_o,
  output gseg_e            s1_seg_o,
  output logic [IDX_W-1:0] s1_idx_o,
  output logic [IP_W-1:0]  s1_frac_o
);
  gseg_e            seg_d;
  logic [IDX_W-1:0] idx_d;
  logic [IP_W-1:0]  frac_d;

  always_comb begin
    seg_d  = SEG_CRS;
    idx_d  = IDX_W'(data_i[FRAC_W-1:IP_W]);
    frac_d = data_i[IP_W-1:0];
    if (|data_i[IN_W-1:FRAC_W]) begin
      seg_d  = SEG_SAT;
      idx_d  = '0;
      frac_d = '0;
    end else if (data_i[FRAC_W-1:SF_BITS] == '0) begin
      seg_d  = SEG_SF;
      idx_d  = IDX_W'(data_i[SF_BITS-1:0]);
      frac_d = '0;
    end else if (data_i[FRAC_W-1:FINE_TOP] == '0) begin
      seg_d  = SEG_FINE;
      idx_d  = IDX_W'(data_i[FINE_TOP-1:SF_BITS]);
      // align the fine fraction to the common interpolation width
      frac_d = {data_i[SF_BITS-1:0], {(IP_W-SF_BITS){1'b0}}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_o <= 1'b0;
      s1_seg_o   <= SEG_SF;
      s1_idx_o   <= '0;
      s1_frac_o  <= '0;
    end else begin
      s1_valid_o <= valid_i;
      if (valid_i) begin
        s1_seg_o  <= seg_d;
        s1_idx_o  <= idx_d;
        s1_frac_o <= frac_d;
      end
    end
  end
endmodule

// File: rtl/gamma_fetch.sv
module gamma_fetch
  import gamma_pkg::*;
#(
  parameter int FRAC_W    = 18,
  parameter int SF_BITS   = 3,
  parameter int FINE_BITS = 8,
  parameter int CRS_BITS  = 8,
  localparam int IP_W     = FRAC_W - CRS_BITS,
  localparam int IDX_W    = FINE_BITS + 1,
  localparam int SFA_W    = SF_BITS + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                s1_valid_i,
  input  gseg_e               s1_seg_i,
  input  logic [IDX_W-1:0]    s1_idx_i,
  input  logic [IP_W-1:0]     s1_frac_i,
  output logic [SFA_W-1:0]    sf_addr_o,
  output logic [IDX_W-1:0]    fine_addr_a_o,
  output logic [IDX_W-1:0]    fine_addr_b_o,
  output logic [CRS_BITS-1:0] crs_addr_a_o,
  output logic [CRS_BITS-1:0] crs_addr_b_o,
  output logic                s2_valid_o,
  output gseg_e               s2_seg_o,
  output logic [IP_W-1:0]     s2_frac_o,
  output logic                s2_top_o
);
  assign sf_addr_o     = SFA_W'(s1_idx_i);
  assign fine_addr_a_o = s1_idx_i;
  assign fine_addr_b_o = s1_idx_i + IDX_W'(1);
  assign crs_addr_a_o  = s1_idx_i[CRS_BITS-1:0];
  assign crs_addr_b_o  = s1_idx_i[CRS_BITS-1:0] + CRS_BITS'(1);

  // last coarse interval: upper bracket comes from the clamp value
  logic top_d;
  assign top_d = (s1_seg_i == SEG_CRS) && (&s1_idx_i[CRS_BITS-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid_o <= 1'b0;
      s2_seg_o   <= SEG_SF;
      s2_frac_o  <= '0;
      s2_top_o   <= 1'b0;
    end else begin
      s2_valid_o <= s1_valid_i;
      if (s1_valid_i) begin
        s2_seg_o  <= s1_seg_i;
        s2_frac_o <= s1_frac_i;
        s2_top_o  <= top_d;
      end
    end
  end
endmodule

// File: rtl/gamma_interp.sv
module gamma_interp
  import gamma_pkg::*;
#(
  parameter int OUT_W = 16,
  parameter int IP_W  = 10,
  localparam int P_W  = OUT_W + IP_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             s2_valid_i,
  input  gseg_e            s2_seg_i,
  input  logic [IP_W-1:0]  s2_frac_i,
  input  logic             s2_top_i,
  input  logic [OUT_W-1:0] sf_data_i,
  input  logic [OUT_W-1:0] fine_data_a_i,
  input  logic [OUT_W-1:0] fine_data_b_i,
  input  logic [OUT_W-1:0] crs_data_a_i,
  input  logic [OUT_W-1:0] crs_data_b_i,
  input  logic [OUT_W-1:0] clamp_max_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] data_o
);
  localparam logic signed [P_W-1:0] RND =
    {{(P_W-IP_W){1'b0}}, 1'b1, {(IP_W-1){1'b0}}};

  logic [OUT_W-1:0] lo, hi;
  always_comb begin
    unique case (s2_seg_i)
      SEG_SF:   begin lo = sf_data_i;     hi = sf_data_i;     end
      SEG_FINE: begin lo = fine_data_a_i; hi = fine_data_b_i; end
      SEG_CRS:  begin lo = crs_data_a_i;  hi = s2_top_i ? clamp_max_i : crs_data_b_i; end
      default:  begin lo = clamp_max_i;   hi = clamp_max_i;   end
    endcase
  end

  logic signed [OUT_W:0]   diff;
  logic signed [IP_W:0]    frac_s;
  logic signed [P_W-1:0]   prod, lo_x, tot;
  logic [IP_W-1:0]         frac_eff;

  assign frac_eff = (s2_seg_i == SEG_SF || s2_seg_i == SEG_SAT) ? '0 : s2_frac_i;
  assign diff     = $signed({1'b0, hi}) - $signed({1'b0, lo});
  assign frac_s   = $signed({1'b0, frac_eff});
  assign prod     = P_W'(diff) * P_W'(frac_s);
  assign lo_x     = $signed({{(P_W-OUT_W){1'b0}}, lo});
  assign tot      = lo_x + ((prod + RND) >>> IP_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= s2_valid_i;
      if (s2_valid_i) data_o <= tot[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/gamma_seg_eval.sv
module gamma_seg_eval
  import gamma_pkg::*;
#(
  parameter int IN_W      = 20,
  parameter int FRAC_W    = 18,
  parameter int OUT_W     = 16,
  parameter int SF_BITS   = 3,
  parameter int FINE_BITS = 8,
  parameter int CRS_BITS  = 8,
  localparam int IP_W     = FRAC_W - CRS_BITS,
  localparam int IDX_W    = FINE_BITS + 1,
  localparam int SFA_W    = SF_BITS + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [IN_W-1:0]     data_i,
  input  logic [OUT_W-1:0]    clamp_max_i,
  output logic [SFA_W-1:0]    sf_addr_o,
  input  logic [OUT_W-1:0]    sf_data_i,
  output logic [IDX_W-1:0]    fine_addr_a_o,
  output logic [IDX_W-1:0]    fine_addr_b_o,
  input  logic [OUT_W-1:0]    fine_data_a_i,
  input  logic [OUT_W-1:0]    fine_data_b_i,
  output logic [CRS_BITS-1:0] crs_addr_a_o,
  output logic [CRS_BITS-1:0] crs_addr_b_o,
  input  logic [OUT_W-1:0]    crs_data_a_i,
  input  logic [OUT_W-1:0]    crs_data_b_i,
  output logic                valid_o,
  output logic [OUT_W-1:0]    data_o
);
  logic             s1_valid, s2_valid, s2_top;
  gseg_e            s1_seg, s2_seg;
  logic [IDX_W-1:0] s1_idx;
  logic [IP_W-1:0]  s1_frac, s2_frac;

  gamma_seg_select #(
    .IN_W(IN_W), .FRAC_W(FRAC_W), .SF_BITS(SF_BITS),
    .FINE_BITS(FINE_BITS), .CRS_BITS(CRS_BITS)
  ) u_sel (
    .clk_i, .rst_ni, .valid_i, .data_i,
    .s1_valid_o(s1_valid), .s1_seg_o(s1_seg),
    .s1_idx_o(s1_idx), .s1_frac_o(s1_frac)
  );

  gamma_fetch #(
    .FRAC_W(FRAC_W), .SF_BITS(SF_BITS),
    .FINE_BITS(FINE_BITS), .CRS_BITS(CRS_BITS)
  ) u_fetch (
    .clk_i, .rst_ni,
    .s1_valid_i(s1_valid), .s1_seg_i(s1_seg),
    .s1_idx_i(s1_idx), .s1_frac_i(s1_frac),
    .sf_addr_o, .fine_addr_a_o, .fine_addr_b_o,
    .crs_addr_a_o, .crs_addr_b_o,
    .s2_valid_o(s2_valid), .s2_seg_o(s2_seg),
    .s2_frac_o(s2_frac), .s2_top_o(s2_top)
  );

  gamma_interp #(.OUT_W(OUT_W), .IP_W(IP_W)) u_interp (
    .clk_i, .rst_ni,
    .s2_valid_i(s2_valid), .s2_seg_i(s2_seg),
    .s2_frac_i(s2_frac), .s2_top_i(s2_top),
    .sf_data_i, .fine_data_a_i, .fine_data_b_i,
    .crs_data_a_i, .crs_data_b_i, .clamp_max_i,
    .valid_o, .data_o
  );
endmodule

// File: rtl/gamma_seg_eval_chk.sv
module gamma_seg_eval_chk #(
  parameter int IN_W      = 20,
  parameter int FRAC_W    = 18,
  parameter int OUT_W     = 16,
  parameter int SF_BITS   = 3,
  parameter int FINE_BITS = 8,
  localparam int IDX_W    = FINE_BITS + 1,
  localparam int SFA_W    = SF_BITS + 1,
  localparam int FINE_TOP = SF_BITS + FINE_BITS
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [IN_W-1:0]  data_i,
  input logic [OUT_W-1:0] clamp_max_i,
  input logic [SFA_W-1:0] sf_addr_o,
  input logic [IDX_W-1:0] fine_addr_a_o,
  input logic             valid_o,
  input logic [OUT_W-1:0] data_o
);
  logic [1:0] warm_cnt;
  logic       warm;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warm_cnt <= '0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
  end
  assign warm = (warm_cnt == 2'd3);

  logic in_sf, in_fine, in_sat;
  assign in_sat  = |data_i[IN_W-1:FRAC_W];
  assign in_sf   = !in_sat && (data_i[FRAC_W-1:SF_BITS] == '0);
  assign in_fine = !in_sat && !in_sf && (data_i[FRAC_W-1:FINE_TOP] == '0);

  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> (valid_o == $past(valid_i, 3)));

  p_sf_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && in_sf) |=> (sf_addr_o == SFA_W'($past(data_i[SF_BITS-1:0]))));

  p_fine_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && in_fine) |=> (fine_addr_a_o == IDX_W'($past(data_i[FINE_TOP-1:SF_BITS]))));

  p_clamp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(valid_i && in_sat, 3)) |-> (data_o == clamp_max_i));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && !valid_o) |-> $stable(data_o));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r8: assert (!valid_o && data_o == '0);
    end
  end
endmodule

bind gamma_seg_eval gamma_seg_eval_chk #(
  .IN_W(IN_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W),
  .SF_BITS(SF_BITS), .FINE_BITS(FINE_BITS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
  .clamp_max_i(clamp_max_i), .sf_addr_o(sf_addr_o),
  .fine_addr_a_o(fine_addr_a_o), .valid_o(valid_o), .data_o(data_o)
);

// File: tb/tb_gamma_seg_eval.sv
module tb_gamma_seg_eval;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        valid_i = 1'b0;
  logic [19:0] data_i = '0;
  logic [15:0] clamp_max_i = 16'hFFF0;
  logic [3:0]  sf_addr_o;
  logic [8:0]  fine_addr_a_o, fine_addr_b_o;
  logic [7:0]  crs_addr_a_o, crs_addr_b_o;
  logic [15:0] sf_data_i, fine_data_a_i, fine_data_b_i, crs_data_a_i, crs_data_b_i;
  logic        valid_o;
  logic [15:0] data_o;

  always #2.5 clk_i = ~clk_i;

  gamma_seg_eval dut (
    .clk_i, .rst_ni, .valid_i, .data_i, .clamp_max_i,
    .sf_addr_o, .sf_data_i,
    .fine_addr_a_o, .fine_addr_b_o, .fine_data_a_i, .fine_data_b_i,
    .crs_addr_a_o, .crs_addr_b_o, .crs_data_a_i, .crs_data_b_i,
    .valid_o, .data_o
  );

  logic [15:0] sf_m [9];
  logic [15:0] fine_m [257];
  logic [15:0] crs_m [256];

  initial begin
    for (int i = 0; i < 9; i++)   sf_m[i]   = 16'(i * 11 + 3);
    for (int i = 0; i < 257; i++) fine_m[i] = 16'(i * 97 + 300) ^ ((i % 2 == 1) ? 16'h0F00 : 16'h0);
    for (int i = 0; i < 256; i++) crs_m[i]  = 16'(i * i * 13 + i * 7);
  end

  always @(posedge clk_i) begin
    sf_data_i     <= sf_m[sf_addr_o];
    fine_data_a_i <= fine_m[fine_addr_a_o];
    fine_data_b_i <= fine_m[fine_addr_b_o];
    crs_data_a_i  <= crs_m[crs_addr_a_o];
    crs_data_b_i  <= crs_m[crs_addr_b_o];
  end

  int n_chk = 0, n_fail = 0;
  logic [15:0] last_out = '0;
  logic        pv [3];
  int unsigned px [3];

  localparam int unsigned VEC [18] = '{
    0, 7, 3, 8, 12, 15, 1001, 2047, 2048, 2560, 3333,
    32'h1_2345, 32'h3_FC00, 32'h3_FE00, 32'h3_FFFF, 32'h4_0000, 32'hF_FFFF, 777
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_out(input int unsigned x);
    longint a, b, f, k;
    if (x >= 32'h4_0000) return int'(clamp_max_i);
    if (x < 8) return int'(sf_m[x]);
    if (x < 2048) begin
      k = x >> 3; f = (x & 7) * 128;
      a = fine_m[k]; b = fine_m[k + 1];
    end else begin
      k = x >> 10; f = x & 1023;
      a = crs_m[k]; b = (k == 255) ? longint'(clamp_max_i) : longint'(crs_m[k + 1]);
    end
    return int'(a + (((b - a) * f + 512) >>> 10));
  endfunction

  function automatic string tag_of(input int unsigned x);
    if (x >= 32'h4_0000) return "R7";
    if (x < 8) return "R2";
    if (x < 2048) return ((x & 7) == 4) ? "R5" : "R3";
    if ((x >> 10) == 255) return "R6";
    return ((x & 1023) == 512) ? "R5" : "R4";
  endfunction

  task automatic step(input logic v, input int unsigned x);
    @(negedge clk_i);
    check(valid_o == pv[2], "R1", int'(valid_o), int'(pv[2]));
    if (pv[2]) begin
      check(data_o == 16'(ref_out(px[2])), tag_of(px[2]), int'(data_o), ref_out(px[2]));
      last_out = data_o;
    end else begin
      check(data_o == last_out, "R9", int'(data_o), int'(last_out));
    end
    pv[2] = pv[1]; px[2] = px[1];
    pv[1] = pv[0]; px[1] = px[0];
    pv[0] = v;     px[0] = x;
    valid_i = v;
    data_i  = x[19:0];
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; px[i] = 0; end
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check(valid_o == 1'b0, "R8", int'(valid_o), 0);
    check(data_o == 16'h0, "R8", int'(data_o), 0);
    rst_ni = 1'b1;

    // back-to-back
    foreach (VEC[i]) step(1'b1, VEC[i]);
    // with bubbles
    foreach (VEC[i]) begin
      step(1'b1, VEC[i]);
      step(1'b0, 32'h1_1111);
    end
    repeat (4) step(1'b0, 0);

    // R1: single pulse latency
    step(1'b1, 100);
    step(1'b0, 0);
    step(1'b0, 0);
    check(valid_o == 1'b0, "R1", int'(valid_o), 0);
    step(1'b0, 0);
    repeat (3) step(1'b0, 0);

    // R6/R7 with another clamp value, changed while idle
    clamp_max_i = 16'h1234;
    repeat (3) step(1'b0, 0);
    step(1'b1, 32'h3_FE00);
    step(1'b1, 32'h3_FC01);
    step(1'b1, 32'h4_0001);
    step(1'b1, 32'h8_0000);
    step(1'b1, 5);
    repeat (4) step(1'b0, 0);

    // sweep across segment boundaries
    for (int x = 0; x < 40; x++) step(1'b1, x);
    for (int x = 2040; x < 2060; x++) step(1'b1, x);
    repeat (4) step(1'b0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule